// File: doc/BRIEF.md
# Retriggerable Finite Pulse Train Generator

This block produces one pulse, or a fixed number of pulses, each time a start trigger arrives. Every interval is counted in active edges of a slow source input, called ticks. The source input, the gate input and the clock are unrelated, so both inputs are resampled in the system clock domain. An active edge of the source is either its rising or its falling edge, chosen by a select pin. A rising edge on the gate starts a generation, but only while the block is armed and idle.

Each pulse is a low interval followed by a high interval. The first low interval after a trigger is either the programmed initial delay or the ordinary low width; a mode input decides which. A timing counter measures each interval. A second counter tallies the finished pulses and ends the generation once the programmed number has been produced. At that point a single-cycle done strobe is raised. While a generation is running, further triggers are ignored, and so are changes to the configuration inputs.

Top module: `pulse_train_gen`

## Requirements
- R1: When `src_fall` is 0, each rising edge of `src_in` counts as one tick. When it is 1, each falling edge counts instead. The output changes only in response to a tick or to `arm` going low.
- R2: A rising edge on `gate_in` while `arm` is high and the block is idle starts a generation. The output is low for the first low interval and then high for `high_ticks` ticks. After that, each later pulse is low for `low_ticks` ticks and then high for `high_ticks` ticks.
- R3: After the high interval of pulse number `pulse_num` ends, the output stays low and `done` is high for exactly one clock cycle, in the cycle where the output falls.
- R4: Rising edges on `gate_in` during a generation have no effect on the output waveform or on `done`.
- R5: `delay_mode` encoding: 2'b01 applies the initial delay on every trigger. 2'b10 applies it only on the first trigger after arming. 2'b00 and 2'b11 select automatic: every trigger when the clamped pulse count is 1, and the first trigger only when the count is greater than 1.
- R6: On a trigger where the initial delay does not apply, the first low interval is `low_ticks` ticks long.
- R7: The first low interval after any trigger lasts at least 2 ticks. Shorter programmed values are raised to 2.
- R8: A value of zero in `high_ticks`, `low_ticks` or `pulse_num` behaves as 1.
- R9: While `arm` is low, the output is low one clock later, a running generation is abandoned without `done`, and gate edges are ignored. After `arm` returns high, the next trigger counts as the first trigger.
- R10: The configuration inputs are captured at the trigger. Changes made to them during a generation do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Level enable; low forces idle and clears the first-trigger record |
| src_in | input | 1 | Timebase source; its active edges are the ticks |
| src_fall | input | 1 | 0: rising edges of src_in are active, 1: falling edges |
| gate_in | input | 1 | Start trigger; rising edge is used |
| delay_ticks | input | TW | Initial delay in ticks |
| high_ticks | input | TW | High width in ticks |
| low_ticks | input | TW | Low width between pulses in ticks |
| pulse_num | input | NW | Pulses per trigger |
| delay_mode | input | 2 | Selects when the initial delay applies (see R5) |
| pulse_out | output | 1 | Generated pulse train |
| done | output | 1 | One-cycle strobe when the final pulse ends |

## Verification
A wrong interval length or a wrong phase shows up as `pulse_out` differing from the tick-based expectation. This is visible at the first sample taken after the tick where the error starts, which is within half a source period. A pulse counter that is off by one shows as an extra or missing high interval, and as `done` arriving early or late or not at all. A lost first-trigger record shifts only the first edge after a retrigger, so repeated triggers are issued with the record both set and cleared. The bench samples in the middle of each tick as well as at its end, so that counting the wrong source edge shows as a half-tick shift.

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int TW = 16,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          src_in,
  input  logic          src_fall,
  input  logic          gate_in,
  input  logic [TW-1:0] delay_ticks,
  input  logic [TW-1:0] high_ticks,
  input  logic [TW-1:0] low_ticks,
  input  logic [NW-1:0] pulse_num,
  input  logic [1:0]    delay_mode,
  output logic          pulse_out,
  output logic          done
);

  localparam logic [TW-1:0] T_ONE = TW'(1);
  localparam logic [TW-1:0] T_TWO = TW'(2);
  localparam logic [NW-1:0] N_ONE = NW'(1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  logic [2:0] src_sh, gate_sh;
  st_t        st;
  logic [TW-1:0] seg_cnt, seg_len, hi_q, lo_q;
  logic [NW-1:0] num_q, pcnt;
  logic          served, done_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_sh  <= '0;
      gate_sh <= '0;
    end else begin
      src_sh  <= {src_sh[1:0], src_in};
      gate_sh <= {gate_sh[1:0], gate_in};
    end

  wire src_tick  = src_fall ? (src_sh[2] & ~src_sh[1]) : (src_sh[1] & ~src_sh[2]);
  wire gate_rise = gate_sh[1] & ~gate_sh[2];

  wire [TW-1:0] hi_c  = (high_ticks == '0) ? T_ONE : high_ticks;
  wire [TW-1:0] lo_c  = (low_ticks  == '0) ? T_ONE : low_ticks;
  wire [NW-1:0] num_c = (pulse_num  == '0) ? N_ONE : pulse_num;

  wire every     = (delay_mode == 2'b01) || ((delay_mode[0] == delay_mode[1]) && (num_c == N_ONE));
  wire [TW-1:0] first_sel = (every || !served) ? delay_ticks : lo_c;
  wire [TW-1:0] first_len = (first_sel < T_TWO) ? T_TWO : first_sel;

  wire seg_last   = (seg_cnt == seg_len - T_ONE);
  wire hi_last    = (seg_cnt == hi_q - T_ONE);
  wire pulse_last = (pcnt == num_q - N_ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      seg_cnt <= '0;
      seg_len <= T_TWO;
      hi_q    <= T_ONE;
      lo_q    <= T_ONE;
      num_q   <= N_ONE;
      pcnt    <= '0;
      served  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!arm) begin
        st     <= S_IDLE;
        served <= 1'b0;
      end else begin
        case (st)
          S_IDLE:
            if (gate_rise) begin
              st      <= S_LOW;
              seg_len <= first_len;
              seg_cnt <= '0;
              hi_q    <= hi_c;
              lo_q    <= lo_c;
              num_q   <= num_c;
              pcnt    <= '0;
              served  <= 1'b1;
            end
          S_LOW:
            if (src_tick) begin
              if (seg_last) begin
                st      <= S_HIGH;
                seg_cnt <= '0;
              end else
                seg_cnt <= seg_cnt + T_ONE;
            end
          S_HIGH:
            if (src_tick) begin
              if (hi_last) begin
                seg_cnt <= '0;
                if (pulse_last) begin
                  st     <= S_IDLE;
                  done_q <= 1'b1;
                end else begin
                  st      <= S_LOW;
                  seg_len <= lo_q;
                  pcnt    <= pcnt + N_ONE;
                end
              end else
                seg_cnt <= seg_cnt + T_ONE;
            end
          default: st <= S_IDLE;
        endcase
      end
    end

  assign pulse_out = (st == S_HIGH);
  assign done      = done_q;

  p_out_moves_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arm) && (pulse_out != $past(pulse_out))) |-> $past(src_tick));

  p_seg_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW) |-> (seg_cnt < seg_len));

  p_done_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pulse_out && $past(pulse_out)));

  p_pulse_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (pcnt < num_q));

  p_gate_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && arm && !src_tick) |=> (st == S_LOW && $stable(seg_cnt)));

  p_arm_low_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!pulse_out && !done));

endmodule

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;

  logic clk = 0, rst_n = 0, arm = 0, src = 0, fall = 0, gate = 0;
  logic [15:0] dly = 0, hi = 0, lo = 0, num = 0;
  logic [1:0] mode = 0;
  logic pulse_out, done;
  int checks = 0, fails = 0, done_cnt = 0;
  bit bserved = 0, finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_train_gen dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .src_in(src), .src_fall(fall),
    .gate_in(gate), .delay_ticks(dly), .high_ticks(hi), .low_ticks(lo),
    .pulse_num(num), .delay_mode(mode), .pulse_out(pulse_out), .done(done)
  );

  always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

  function automatic int clampz(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_out(int k, int f, int h, int l, int c);
    if (k < f) return 0;
    k -= f;
    for (int p = 0; p < c; p++) begin
      if (k < h) return 1;
      k -= h;
      if (p == c - 1) return 0;
      if (k < l) return 0;
      k -= l;
    end
    return 0;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_gate();
    gate = 1;
    repeat (HALF) @(negedge clk);
    gate = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_tick();
    src = 1;
    repeat (HALF) @(negedge clk);
    src = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_case(int d, int h, int l, int c, logic [1:0] m, bit fe, bit disturb, string req);
    int hc, lc, cc, f, total, base, k;
    bit every;
    hc = clampz(h); lc = clampz(l); cc = clampz(c);
    every = (m == 2'b01) || ((m == 2'b00 || m == 2'b11) && cc == 1);
    f = (every || !bserved) ? d : lc;
    if (f < 2) f = 2;
    total = f + cc * hc + (cc - 1) * lc;
    dly = 16'(d); hi = 16'(h); lo = 16'(l); num = 16'(c); mode = m; fall = fe;
    @(negedge clk);
    base = done_cnt;
    pulse_gate();
    bserved = 1;
    check_eq(req, "output low right after trigger", int'(pulse_out), 0);
    k = 0;
    for (int t = 0; t < total + 2; t++) begin
      if (disturb && t == 1) begin
        // R10: configuration changes mid-run must not matter
        dly = 16'($urandom_range(0, 7)); hi = 16'($urandom_range(0, 7));
        lo = 16'($urandom_range(0, 7)); num = 16'($urandom_range(0, 5));
        mode = 2'($urandom_range(0, 3));
      end
      if (disturb && t == total / 2) begin
        pulse_gate(); // R4: retrigger during generation ignored
        check_eq("R4", "output after gate during run", int'(pulse_out), exp_out(k, f, hc, lc, cc));
      end
      src = 1;
      repeat (HALF) @(negedge clk);
      if (!fe) k++;
      check_eq(req, "pulse_out mid tick (R1 edge select)", int'(pulse_out), exp_out(k, f, hc, lc, cc));
      check_eq(req, "done count mid tick", done_cnt - base, (k >= total) ? 1 : 0);
      src = 0;
      repeat (HALF) @(negedge clk);
      if (fe) k++;
      check_eq(req, "pulse_out end of tick", int'(pulse_out), exp_out(k, f, hc, lc, cc));
      check_eq(req, "done count end of tick (R3)", done_cnt - base, (k >= total) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_eq("R3", "done during reset", int'(done), 0);
    check_eq("R2", "pulse_out during reset", int'(pulse_out), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    arm = 1;
    repeat (2) @(negedge clk);
    check_eq("R2", "pulse_out idle after arm", int'(pulse_out), 0);

    // two pulses, delay 5, width 3, in both delay settings
    run_case(5, 3, 3, 2, 2'b00, 0, 0, "R5");
    run_case(5, 3, 3, 2, 2'b00, 0, 0, "R6");
    run_case(5, 3, 3, 2, 2'b01, 0, 0, "R5");
    run_case(5, 3, 3, 2, 2'b10, 0, 0, "R6");
    // falling edge as active
    run_case(2, 2, 1, 3, 2'b01, 1, 0, "R1");
    // zero values and minimum first interval
    run_case(0, 0, 0, 0, 2'b01, 0, 0, "R8");
    run_case(1, 1, 1, 2, 2'b10, 0, 0, "R7");
    // single pulse in automatic mode keeps the delay each time
    run_case(4, 2, 1, 1, 2'b11, 0, 0, "R5");
    run_case(4, 2, 1, 1, 2'b00, 1, 0, "R5");
    // disturbance during run
    run_case(3, 2, 2, 3, 2'b10, 0, 1, "R10");

    // R9: abort by arm low
    dly = 2; hi = 4; lo = 1; num = 3; mode = 2'b01; fall = 0;
    @(negedge clk);
    base = done_cnt;
    pulse_gate();
    repeat (3) do_tick();
    check_eq("R9", "output high before abort", int'(pulse_out), 1);
    arm = 0;
    repeat (2) @(negedge clk);
    check_eq("R9", "output low after arm drop", int'(pulse_out), 0);
    repeat (12) do_tick();
    check_eq("R9", "output still low while disarmed", int'(pulse_out), 0);
    pulse_gate();
    repeat (6) do_tick();
    check_eq("R9", "gate ignored while disarmed", int'(pulse_out), 0);
    check_eq("R9", "no done after abort", done_cnt - base, 0);
    arm = 1;
    bserved = 0;
    repeat (2) @(negedge clk);
    run_case(6, 1, 2, 2, 2'b10, 0, 0, "R9");

    for (int i = 0; i < 14; i++)
      run_case($urandom_range(0, 6), $urandom_range(0, 5), $urandom_range(0, 5),
               $urandom_range(0, 4), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), "R2");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule